// File: doc/BRIEF.md
# Status Word and Exception Entry Controller

This block keeps the processor's 32-bit status word and decides, cycle by cycle, whether an exception is taken. The status word holds the four ALU condition flags, the two interrupt masks, the instruction-state bit and a five-bit mode field. The ALU updates the flags. Software can write the whole word. An exception-return strobe restores the word from the saved copy that belongs to the current mode.

Exception requests arrive on seven inputs. Two are interrupt levels: the normal interrupt and the fast interrupt. Each is taken only while its input is high and its mask bit is clear. The other five are single-cycle pulses: reset, data abort, prefetch abort, undefined instruction and supervisor call. Requests are resolved combinationally against the current status word. In the same cycle the block presents a vector address, the new mode, and a link-register write that carries the incoming program counter value. At the next clock edge it saves the old word into the new mode's saved-status slot and installs the new mode and masks. The register file and the fetch unit consume the entry outputs. Neither is part of this block.

Top module: `psr_exc_ctrl`

## Requirements
- R1: The status word keeps flag N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. It keeps the normal-interrupt mask in bit 7, the fast-interrupt mask in bit 6, the instruction-state bit in bit 5 (0 selects 32-bit instructions, 1 selects compressed 16-bit instructions) and the mode in bits 4:0. Bits 27:8 always read zero. A word write stores only the bits listed here.
- R2: A flag update with no higher-precedence action loads flag_nzcv (N in its MSB) into bits 31:28 at the next edge and leaves every other bit unchanged.
- R3: While rst_n is low, the status word is 0x000000D3 (supervisor mode, both masks set, T clear) and every saved-status slot is zero.
- R4: A high irq_req is taken only while bit 7 is 0. While bit 7 is 1 it produces no entry.
- R5: A high fiq_req is taken only while bit 6 is 0. While bit 6 is 1 it produces no entry.
- R6: When several unmasked requests are present, the one taken is chosen in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, supervisor call.
- R7: exc_take rises in the same cycle as the request. vec_pc is then VEC_BASE plus an offset: 0x00 for reset, 0x04 for undefined, 0x08 for supervisor call, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for the normal interrupt and 0x1C for the fast interrupt.
- R8: In an entry cycle, lr_we is 1, lr_data equals pc_in and lr_mode is the new mode. Outside entry cycles, lr_we is 0.
- R9: At the edge that ends an entry cycle, the mode field takes the new mode, bit 7 is set and bit 5 is cleared. Bit 6 is set for fast interrupt and reset entries and is kept as it was for all others. The flags are kept.
- R10: At the same edge, the pre-entry status word is stored in the new mode's saved-status slot. saved_psw always shows the slot of the current mode, and shows zero in user and system modes.
- R11: ret_req copies the current mode's saved status into the status word at the next edge. In user or system mode it has no effect.
- R12: Within one cycle, an exception entry takes precedence over a return, a return over a word write, and a word write over a flag update.
- R13: The mode encodings are user 0x10, fast interrupt 0x11, normal interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. Both abort kinds enter 0x17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Load the condition flags |
| flag_nzcv | input | 4 | New N, Z, C, V flags, N in bit 3 |
| psw_we | input | 1 | Write the whole status word |
| psw_wdata | input | 32 | Status word write data |
| ret_req | input | 1 | Restore the status word from the current mode's saved copy |
| irq_req | input | 1 | Normal interrupt request level |
| fiq_req | input | 1 | Fast interrupt request level |
| rst_req | input | 1 | Reset exception pulse |
| und_req | input | 1 | Undefined instruction pulse |
| svc_req | input | 1 | Supervisor call pulse |
| pabt_req | input | 1 | Prefetch abort pulse |
| dabt_req | input | 1 | Data abort pulse |
| pc_in | input | ADDR_W | Program counter value to preserve on entry |
| psw | output | 32 | Current status word |
| saved_psw | output | 32 | Saved status of the current mode |
| exc_take | output | 1 | An exception is entered this cycle |
| vec_pc | output | ADDR_W | Vector address for the program counter |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | ADDR_W | Return address to write |

## Verification
A wrong mask bit, mode field or saved slot shows at the ports within one cycle. An interrupt that should be refused still raises exc_take. Entry or return leaves a psw value that differs from the expected one. saved_psw returns a stale or misplaced copy as soon as the mode changes. The bench's behavioural model predicts psw, saved_psw and the entry outputs every clock. A corrupted bank or priority therefore fails at the first cycle where it matters, and does not wait for a later return.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int PSW_W   = 32;
   localparam int MODE_W  = 5;
   localparam int KIND_N  = 7;
   localparam int KIND_W  = $clog2(KIND_N);
   localparam int BANK_N  = 5;

   localparam logic [MODE_W-1:0] M_USR = 5'h10;
   localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
   localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
   localparam logic [MODE_W-1:0] M_SVC = 5'h13;
   localparam logic [MODE_W-1:0] M_ABT = 5'h17;
   localparam logic [MODE_W-1:0] M_UND = 5'h1B;
   localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

   localparam logic [PSW_W-1:0] PSW_KEEP  = 32'hF000_00FF;
   localparam logic [PSW_W-1:0] PSW_RESET = 32'h0000_00D3;

   // request index order is the priority order, 0 highest
   localparam int K_RST  = 0;
   localparam int K_DABT = 1;
   localparam int K_FIQ  = 2;
   localparam int K_IRQ  = 3;
   localparam int K_PABT = 4;
   localparam int K_UND  = 5;
   localparam int K_SVC  = 6;

   function automatic logic [MODE_W-1:0] kind_mode(input logic [KIND_W-1:0] k);
      case (k)
         KIND_W'(K_RST):  kind_mode = M_SVC;
         KIND_W'(K_DABT): kind_mode = M_ABT;
         KIND_W'(K_FIQ):  kind_mode = M_FIQ;
         KIND_W'(K_IRQ):  kind_mode = M_IRQ;
         KIND_W'(K_PABT): kind_mode = M_ABT;
         KIND_W'(K_UND):  kind_mode = M_UND;
         default:         kind_mode = M_SVC;
      endcase
   endfunction

   function automatic logic [7:0] kind_offset(input logic [KIND_W-1:0] k);
      case (k)
         KIND_W'(K_RST):  kind_offset = 8'h00;
         KIND_W'(K_DABT): kind_offset = 8'h10;
         KIND_W'(K_FIQ):  kind_offset = 8'h1C;
         KIND_W'(K_IRQ):  kind_offset = 8'h18;
         KIND_W'(K_PABT): kind_offset = 8'h0C;
         KIND_W'(K_UND):  kind_offset = 8'h04;
         default:         kind_offset = 8'h08;
      endcase
   endfunction

   function automatic logic kind_sets_f(input logic [KIND_W-1:0] k);
      kind_sets_f = (k == KIND_W'(K_RST)) || (k == KIND_W'(K_FIQ));
   endfunction

   function automatic logic [MODE_W-1:0] bank_mode(input int b);
      case (b)
         0:       bank_mode = M_FIQ;
         1:       bank_mode = M_IRQ;
         2:       bank_mode = M_SVC;
         3:       bank_mode = M_ABT;
         default: bank_mode = M_UND;
      endcase
   endfunction
endpackage

// File: rtl/psr_arbiter.sv
module psr_arbiter #(
   parameter int N = 7,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("psr_arbiter needs at least two requests");
   end

   for (genvar i = 0; i < N; i++) begin : g_pri
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
   import psr_pkg::*;
#(
   parameter int W  = PSW_W,
   parameter int NB = BANK_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic [W-1:0]      wr_data,
   input  logic [MODE_W-1:0] rd_mode,
   output logic [W-1:0]      rd_data,
   output logic              rd_valid
);
   if (NB < 1 || NB > BANK_N) begin : g_bad_nb
      $error("psr_saved_bank: NB out of range");
   end

   logic [W-1:0]  slot_q [NB];
   logic [NB-1:0] rd_hit;

   for (genvar b = 0; b < NB; b++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              slot_q[b] <= '0;
         else if (wr_en && wr_mode == bank_mode(b)) slot_q[b] <= wr_data;
      end
      assign rd_hit[b] = (rd_mode == bank_mode(b));
   end

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NB; b++) begin
         if (rd_hit[b]) rd_data = rd_data | slot_q[b];
      end
   end

   assign rd_valid = |rd_hit;
endmodule

// File: rtl/psr_vector.sv
module psr_vector
   import psr_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic [KIND_W-1:0] kind,
   output logic [ADDR_W-1:0] vec
);
   assign vec = VEC_BASE + ADDR_W'(kind_offset(kind));
endmodule

// File: rtl/psr_exc_ctrl.sv
module psr_exc_ctrl
   import psr_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flag_we,
   input  logic [3:0]        flag_nzcv,
   input  logic              psw_we,
   input  logic [31:0]       psw_wdata,
   input  logic              ret_req,
   input  logic              irq_req,
   input  logic              fiq_req,
   input  logic              rst_req,
   input  logic              und_req,
   input  logic              svc_req,
   input  logic              pabt_req,
   input  logic              dabt_req,
   input  logic [ADDR_W-1:0] pc_in,
   output logic [31:0]       psw,
   output logic [31:0]       saved_psw,
   output logic              exc_take,
   output logic [ADDR_W-1:0] vec_pc,
   output logic              lr_we,
   output logic [4:0]        lr_mode,
   output logic [ADDR_W-1:0] lr_data
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("psr_exc_ctrl: ADDR_W must be at least 8");
   end
   if (VEC_BASE[4:0] != 5'd0) begin : g_bad_base
      $error("psr_exc_ctrl: VEC_BASE must be 32-byte aligned");
   end

   logic [PSW_W-1:0]  psw_q, psw_d;
   logic [KIND_N-1:0] req, grant;
   logic              take;
   logic [KIND_W-1:0] kind;
   logic [MODE_W-1:0] new_mode;
   logic [PSW_W-1:0]  saved_rd;
   logic              saved_ok;

   always_comb begin
      req         = '0;
      req[K_RST]  = rst_req;
      req[K_DABT] = dabt_req;
      req[K_FIQ]  = fiq_req & ~psw_q[6];
      req[K_IRQ]  = irq_req & ~psw_q[7];
      req[K_PABT] = pabt_req;
      req[K_UND]  = und_req;
      req[K_SVC]  = svc_req;
   end

   psr_arbiter #(.N(KIND_N)) u_arb (
      .req   (req),
      .grant (grant),
      .any   (take),
      .idx   (kind)
   );

   assign new_mode = kind_mode(kind);

   psr_saved_bank #(.W(PSW_W), .NB(BANK_N)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (take),
      .wr_mode  (new_mode),
      .wr_data  (psw_q),
      .rd_mode  (psw_q[4:0]),
      .rd_data  (saved_rd),
      .rd_valid (saved_ok)
   );

   psr_vector #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
      .kind (kind),
      .vec  (vec_pc)
   );

   always_comb begin
      psw_d = psw_q;
      if (take)
         psw_d = {psw_q[31:8], 1'b1, psw_q[6] | kind_sets_f(kind), 1'b0, new_mode};
      else if (ret_req && saved_ok)
         psw_d = saved_rd;
      else if (psw_we)
         psw_d = psw_wdata & PSW_KEEP;
      else if (flag_we)
         psw_d[31:28] = flag_nzcv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psw_q <= PSW_RESET;
      else        psw_q <= psw_d;
   end

   assign psw       = psw_q;
   assign saved_psw = saved_rd;
   assign exc_take  = take;
   assign lr_we     = take;
   assign lr_mode   = new_mode;
   assign lr_data   = pc_in;

   // ---------------- assertions ----------------
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      psw[27:8] == 20'd0);

   assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      psw[7] |-> !grant[K_IRQ]);

   assert_fiq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      psw[6] |-> !grant[K_FIQ]);

   assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (exc_take == (grant != '0)));

   assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |-> ((vec_pc - VEC_BASE) <= ADDR_W'(8'h1C)) && (vec_pc[1:0] == 2'b00));

   assert_flag_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && flag_we && !psw_we && !ret_req && !exc_take) |=>
      (psw[31:28] == $past(flag_nzcv)) && (psw[7:0] == $past(psw[7:0])));

   assert_entry_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && exc_take) |=>
      psw[7] && !psw[5] && (psw[4:0] == $past(lr_mode)) && (psw[31:28] == $past(psw[31:28])));

   assert_saved_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && exc_take) |=> (saved_psw == $past(psw)));

   assert_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ret_req && !exc_take && saved_ok) |=> (psw == $past(saved_psw)));
endmodule

// File: tb/psr_exc_ctrl_bench.sv
module psr_exc_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flag_we = 0, psw_we = 0, ret_req = 0;
   logic [3:0]  flag_nzcv = '0;
   logic [31:0] psw_wdata = '0;
   logic        irq_req = 0, fiq_req = 0, rst_req = 0, und_req = 0;
   logic        svc_req = 0, pabt_req = 0, dabt_req = 0;
   logic [31:0] pc_in = '0;
   logic [31:0] psw, saved_psw, vec_pc, lr_data;
   logic        exc_take, lr_we;
   logic [4:0]  lr_mode;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   psr_exc_ctrl u_psr_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_nzcv(flag_nzcv),
      .psw_we(psw_we), .psw_wdata(psw_wdata), .ret_req(ret_req),
      .irq_req(irq_req), .fiq_req(fiq_req), .rst_req(rst_req), .und_req(und_req),
      .svc_req(svc_req), .pabt_req(pabt_req), .dabt_req(dabt_req), .pc_in(pc_in),
      .psw(psw), .saved_psw(saved_psw), .exc_take(exc_take), .vec_pc(vec_pc),
      .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data)
   );

   // behavioural reference state
   logic [31:0] m_psw;
   logic [31:0] m_saved [32];
   logic [31:0] n_psw;
   logic        n_wr;
   logic [4:0]  n_wmode;

   function automatic bit has_slot(input logic [4:0] m);
      return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic clr_in();
      flag_we = 0; psw_we = 0; ret_req = 0; irq_req = 0; fiq_req = 0;
      rst_req = 0; und_req = 0; svc_req = 0; pabt_req = 0; dabt_req = 0;
   endtask

   // compare outputs with the model and prepare the next model state
   task automatic settle();
      bit          e_take;
      logic [4:0]  e_mode;
      logic [31:0] e_vec;
      bit          e_setf;
      #1;
      e_take = 1; e_setf = 0; e_mode = 5'h13; e_vec = 0;
      if (rst_req)                        begin e_mode = 5'h13; e_vec = 32'h00; e_setf = 1; end
      else if (dabt_req)                  begin e_mode = 5'h17; e_vec = 32'h10; end
      else if (fiq_req && !m_psw[6])      begin e_mode = 5'h11; e_vec = 32'h1C; e_setf = 1; end
      else if (irq_req && !m_psw[7])      begin e_mode = 5'h12; e_vec = 32'h18; end
      else if (pabt_req)                  begin e_mode = 5'h17; e_vec = 32'h0C; end
      else if (und_req)                   begin e_mode = 5'h1B; e_vec = 32'h04; end
      else if (svc_req)                   begin e_mode = 5'h13; e_vec = 32'h08; end
      else e_take = 0;

      chk(psw, m_psw, "R1");
      chk(saved_psw, has_slot(m_psw[4:0]) ? m_saved[m_psw[4:0]] : 32'h0, "R10");
      chk(32'(exc_take), 32'(e_take), "R7");
      chk(32'(lr_we), 32'(e_take), "R8");
      if (e_take) begin
         chk(vec_pc, e_vec, "R7");
         chk(32'(lr_mode), 32'(e_mode), "R8");
         chk(lr_data, pc_in, "R8");
      end

      n_psw = m_psw; n_wr = 0; n_wmode = e_mode;
      if (e_take) begin
         n_wr = 1;
         n_psw[7] = 1'b1;
         if (e_setf) n_psw[6] = 1'b1;
         n_psw[5] = 1'b0;
         n_psw[4:0] = e_mode;
      end else if (ret_req && has_slot(m_psw[4:0])) n_psw = m_saved[m_psw[4:0]];
      else if (psw_we)  n_psw = psw_wdata & 32'hF000_00FF;
      else if (flag_we) n_psw[31:28] = flag_nzcv;
   endtask

   task automatic advance();
      @(posedge clk);
      if (n_wr) m_saved[n_wmode] = m_psw;
      m_psw = n_psw;
      @(negedge clk);
   endtask

   task automatic tick();
      settle();
      advance();
   endtask

   task automatic wr_psw(input logic [31:0] v);
      clr_in(); psw_we = 1; psw_wdata = v; tick(); clr_in();
   endtask

   function automatic logic [4:0] pick_mode(input int n);
      case (n % 7)
         0: return 5'h10; 1: return 5'h11; 2: return 5'h12; 3: return 5'h13;
         4: return 5'h17; 5: return 5'h1B; default: return 5'h1F;
      endcase
   endfunction

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_psw = 32'h0000_00D3;
      for (int i = 0; i < 32; i++) m_saved[i] = '0;
      clr_in();
      repeat (3) @(negedge clk);
      chk(psw, 32'h0000_00D3, "R3");
      chk(saved_psw, 32'h0, "R3");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: word write keeps only defined bits
      wr_psw(32'hFFFF_FFF0);
      settle(); chk(psw, 32'hF000_00F0, "R1"); advance();

      // R2: flag update alone
      flag_we = 1; flag_nzcv = 4'h5; tick(); clr_in();
      settle(); chk(psw, 32'h5000_00F0, "R2"); advance();

      // R12: word write beats flag update
      psw_we = 1; psw_wdata = 32'h0000_0090; flag_we = 1; flag_nzcv = 4'hF; tick(); clr_in();
      settle(); chk(psw, 32'h0000_0090, "R12"); advance();

      // R4: interrupt masked while bit 7 is set
      irq_req = 1; settle(); chk(32'(exc_take), 0, "R4"); advance(); clr_in();

      // R4/R7/R8: taken when unmasked
      wr_psw(32'h8000_0010);
      irq_req = 1; pc_in = 32'h0000_1234; settle();
      chk(32'(exc_take), 1, "R4"); chk(vec_pc, 32'h18, "R7");
      chk(lr_data, 32'h0000_1234, "R8"); chk(32'(lr_mode), 32'h12, "R13");
      advance(); clr_in();
      settle(); chk(psw, 32'h8000_0092, "R9"); chk(saved_psw, 32'h8000_0010, "R10"); advance();

      // R12: entry beats return; R11 return
      und_req = 1; ret_req = 1; settle(); chk(32'(lr_mode), 32'h1B, "R12"); advance(); clr_in();
      ret_req = 1; tick(); clr_in();
      settle(); chk(psw, 32'h8000_0092, "R11"); advance();
      ret_req = 1; tick(); clr_in();
      settle(); chk(psw, 32'h8000_0010, "R11"); advance();

      // R11: return in user mode does nothing
      ret_req = 1; tick(); clr_in();
      settle(); chk(psw, 32'h8000_0010, "R11"); advance();

      // R5: fast interrupt masked by bit 6
      wr_psw(32'h0000_0050);
      fiq_req = 1; settle(); chk(32'(exc_take), 0, "R5"); advance(); clr_in();

      // R6: fast beats normal interrupt; R9 sets F
      wr_psw(32'h0000_0010);
      fiq_req = 1; irq_req = 1; settle(); chk(vec_pc, 32'h1C, "R6"); advance(); clr_in();
      settle(); chk(psw, 32'h0000_00D1, "R9"); advance();

      // R6: reset beats data abort; R13 modes for the pulse kinds
      wr_psw(32'h0000_0010);
      rst_req = 1; dabt_req = 1; settle(); chk(vec_pc, 32'h00, "R6"); advance(); clr_in();
      wr_psw(32'h0000_0010);
      pabt_req = 1; svc_req = 1; settle(); chk(32'(lr_mode), 32'h17, "R13"); advance(); clr_in();
      wr_psw(32'h0000_0010);
      svc_req = 1; settle(); chk(32'(lr_mode), 32'h13, "R13"); chk(vec_pc, 32'h08, "R7"); advance(); clr_in();

      // random traffic against the model
      for (int c = 0; c < 3000; c++) begin
         logic [31:0] r;
         r = $urandom;
         rst_req  = ($urandom % 40) == 0;
         dabt_req = ($urandom % 16) == 0;
         pabt_req = ($urandom % 16) == 0;
         und_req  = ($urandom % 16) == 0;
         svc_req  = ($urandom % 16) == 0;
         if (($urandom % 4) == 0) irq_req = ~irq_req;
         if (($urandom % 5) == 0) fiq_req = ~fiq_req;
         ret_req  = ($urandom % 6) == 0;
         psw_we   = ($urandom % 6) == 0;
         psw_wdata = {r[31:5], pick_mode(int'($urandom % 7))};
         flag_we  = ($urandom % 3) == 0;
         flag_nzcv = 4'($urandom);
         pc_in    = $urandom;
         tick();
      end
      clr_in();
      tick();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule